// File: doc/BRIEF.md
# Three-Level Control Pulse Decoder

This block reads one control line that can rest at a middle level, drop to a low level, rise to a high level, or be driven to a still higher programming level. Three comparator flags describe the line: below the low threshold, above the high threshold, and above the programming threshold. The decoder synchronizes them and measures how long each excursion lasts with a 1 µs tick. It turns excursions that qualify into single-cycle request strobes for an external up/down counter and its non-volatile store.

A low excursion asks for an increment and a high excursion asks for a decrement. Short glitches produce nothing. Counting requests only go out once the enable input has been high for a start-up interval. The first qualified counting pulse after reset and the first one after each programming event are thrown away, because the comparators cannot be trusted at those points. A program request does not depend on the enable input.

Top module: `tri_level_pulse_decoder`

## Requirements
- R1: A low-only excursion (`ctl_below`=1, `ctl_above`=0) held for ACCEPT_US (200) ticks gives one `inc_req` strobe. A high-only excursion (`ctl_above`=1, `ctl_below`=0) held that long gives one `dec_req` strobe.
- R2: An excursion that returns to the middle level before ACCEPT_US ticks gives no strobe. This holds for glitches under 20 ticks and for widths up to 199 ticks.
- R3: Each strobe lasts one clock cycle. An excursion gives at most one request however long it is held. At most one of the three strobes is high in any cycle.
- R4: An excursion counts only if the line sat at the middle level (both flags 0) for at least GAP_US (10) ticks just before it. Otherwise the whole excursion is ignored.
- R5: After reset, the first counting pulse that would otherwise be honoured is discarded without a strobe.
- R6: After each `prog_req`, the next counting pulse that would otherwise be honoured is discarded.
- R7: While `count_en` is low, no `inc_req` or `dec_req` is issued.
- R8: Counting pulses are honoured only after `count_en` has been high for STARTUP_US (1000) ticks in a row. A pulse that qualifies earlier is dropped and does not use up the discard of R5/R6.
- R9: `ctl_prog` held high for PROG_US (200) ticks gives one `prog_req`, whatever the level of `count_en`. An excursion during which `ctl_prog` was seen never gives an increment or decrement.
- R10: When `ctl_below` and `ctl_above` are high together, the line is treated as invalid. No strobe results, and the invalid span does not count as middle level.
- R11: A synchronous active-high reset clears all three strobes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| ctl_below | input | 1 | Line below the low threshold (asynchronous) |
| ctl_above | input | 1 | Line above the high threshold (asynchronous) |
| ctl_prog | input | 1 | Line above the programming threshold (asynchronous) |
| count_en | input | 1 | Counting enable (asynchronous) |
| inc_req | output | 1 | Increment request strobe |
| dec_req | output | 1 | Decrement request strobe |
| prog_req | output | 1 | Program request strobe |

## Verification
Some properties are checked by assertions on every cycle. These are: strobes are mutually exclusive and one cycle long, a count strobe always follows a cycle in which the start-up interval was complete and enable was high, and a qualification never comes from an invalid or freshly changed level. Other behaviours need a history of ticks and can only be shown by the bench scenarios. These are: the width threshold, the middle-level gap, the discard after reset and after programming, and the start-up delay. Those scenarios compare strobe counts per excursion with a bench model, using directed corner cases and a seeded random sequence of long, short and invalid excursions.

// File: rtl/tlpd_pkg.sv
package tlpd_pkg;

  // Encoding is {above, below}
  typedef enum logic [1:0] {
    LVL_MID = 2'b00,
    LVL_LO  = 2'b01,
    LVL_HI  = 2'b10,
    LVL_BAD = 2'b11
  } lvl_e;

  function automatic lvl_e classify(input logic below, input logic above);
    return lvl_e'({above, below});
  endfunction

endpackage

// File: rtl/tlpd_sync.sv
module tlpd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int SHW = W * STAGES;

  logic [SHW-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[SHW-W-1:0], d};
      end
    end
  endgenerate

  assign q = shreg[SHW-1 -: W];

endmodule

// File: rtl/tlpd_qual.sv
module tlpd_qual
  import tlpd_pkg::*;
#(
  parameter int ACCEPT_US = 200,
  parameter int GAP_US    = 10,
  parameter int PROG_US   = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lo_s,
  input  logic hi_s,
  input  logic pg_s,
  output logic qual_o,
  output logic qual_dn_o,
  output logic prog_o
);

  localparam int EW = $clog2(ACCEPT_US + 1);
  localparam int GW = $clog2(GAP_US + 1);
  localparam int PW = $clog2(PROG_US + 1);

  lvl_e          lvl, lvl_q;
  logic [EW-1:0] exc_cnt;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] pg_cnt;
  logic          eligible, done, tainted, pg_done;
  logic          changed, gap_ok, is_exc;

  always_comb begin
    lvl     = classify(lo_s, hi_s);
    changed = (lvl != lvl_q);
    gap_ok  = (gap_cnt == GW'(GAP_US));
    is_exc  = (lvl == LVL_LO) || (lvl == LVL_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= LVL_MID;
      exc_cnt   <= '0;
      gap_cnt   <= '0;
      pg_cnt    <= '0;
      eligible  <= 1'b0;
      done      <= 1'b0;
      tainted   <= 1'b0;
      pg_done   <= 1'b0;
      qual_o    <= 1'b0;
      qual_dn_o <= 1'b0;
      prog_o    <= 1'b0;
    end else begin
      qual_o <= 1'b0;
      prog_o <= 1'b0;
      lvl_q  <= lvl;

      // middle-level dwell, saturating
      if (lvl != LVL_MID)          gap_cnt <= '0;
      else if (tick && !gap_ok)    gap_cnt <= gap_cnt + 1'b1;

      // excursion width measurement
      if (changed) begin
        exc_cnt  <= '0;
        done     <= 1'b0;
        tainted  <= pg_s;
        eligible <= is_exc && (lvl_q == LVL_MID) && gap_ok;
      end else begin
        if (pg_s) tainted <= 1'b1;
        if (is_exc && eligible && !done && tick) begin
          if (exc_cnt == EW'(ACCEPT_US - 1)) begin
            done      <= 1'b1;
            qual_o    <= !(tainted || pg_s);
            qual_dn_o <= (lvl == LVL_HI);
          end else begin
            exc_cnt <= exc_cnt + 1'b1;
          end
        end
      end

      // programming level width measurement
      if (!pg_s) begin
        pg_cnt  <= '0;
        pg_done <= 1'b0;
      end else if (tick && !pg_done) begin
        if (pg_cnt == PW'(PROG_US - 1)) begin
          pg_done <= 1'b1;
          prog_o  <= 1'b1;
        end else begin
          pg_cnt <= pg_cnt + 1'b1;
        end
      end
    end
  end

  AST_NO_BAD_QUAL: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> ($past(lvl) != LVL_BAD)); // R10
  AST_QUAL_HELD: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> ($past(lvl) == $past(lvl_q))); // R1
  AST_QUAL_NOT_PROG: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> !$past(pg_s)); // R9
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= GW'(GAP_US)); // R4

endmodule

// File: rtl/tlpd_gate.sv
module tlpd_gate #(
  parameter int STARTUP_US = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en_s,
  input  logic qual_i,
  input  logic qual_dn_i,
  input  logic prog_i,
  output logic inc_o,
  output logic dec_o,
  output logic prog_o
);

  localparam int SW = $clog2(STARTUP_US + 1);

  logic [SW-1:0] st_cnt;
  logic          ready;
  logic          primed;

  assign ready = (st_cnt == SW'(STARTUP_US));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_cnt <= '0;
      primed <= 1'b0;
      inc_o  <= 1'b0;
      dec_o  <= 1'b0;
      prog_o <= 1'b0;
    end else begin
      inc_o  <= 1'b0;
      dec_o  <= 1'b0;
      prog_o <= prog_i;

      if (!en_s)               st_cnt <= '0;
      else if (tick && !ready) st_cnt <= st_cnt + 1'b1;

      if (prog_i) begin
        primed <= 1'b0;
      end else if (qual_i && en_s && ready) begin
        if (primed) begin
          inc_o <= !qual_dn_i;
          dec_o <= qual_dn_i;
        end else begin
          primed <= 1'b1;
        end
      end
    end
  end

  AST_COUNT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    (inc_o || dec_o) |-> $past(ready && en_s)); // R8
  AST_COUNT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (inc_o || dec_o) |-> $past(en_s)); // R7
  AST_COUNT_NEEDS_QUAL: assert property (@(posedge clk) disable iff (rst)
    (inc_o || dec_o) |-> $past(qual_i)); // R1

endmodule

// File: rtl/tri_level_pulse_decoder.sv
module tri_level_pulse_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int ACCEPT_US   = 200,
  parameter int GAP_US      = 10,
  parameter int PROG_US     = 200,
  parameter int STARTUP_US  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic ctl_below,
  input  logic ctl_above,
  input  logic ctl_prog,
  input  logic count_en,
  output logic inc_req,
  output logic dec_req,
  output logic prog_req
);

  localparam int NIN = 4;

  logic [NIN-1:0] raw, synced;
  logic           qual, qual_dn, prog_evt;

  assign raw = {count_en, ctl_prog, ctl_above, ctl_below};

  tlpd_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  tlpd_qual #(.ACCEPT_US(ACCEPT_US), .GAP_US(GAP_US), .PROG_US(PROG_US)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_us),
    .lo_s      (synced[0]),
    .hi_s      (synced[1]),
    .pg_s      (synced[2]),
    .qual_o    (qual),
    .qual_dn_o (qual_dn),
    .prog_o    (prog_evt)
  );

  tlpd_gate #(.STARTUP_US(STARTUP_US)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_us),
    .en_s      (synced[3]),
    .qual_i    (qual),
    .qual_dn_i (qual_dn),
    .prog_i    (prog_evt),
    .inc_o     (inc_req),
    .dec_o     (dec_req),
    .prog_o    (prog_req)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inc_req, dec_req, prog_req})); // R3
  AST_INC_PULSE: assert property (@(posedge clk) disable iff (rst)
    inc_req |=> !inc_req); // R3
  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (rst)
    dec_req |=> !dec_req); // R3
  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req); // R9

endmodule

// File: tb/tri_level_pulse_decoder_bench.sv
module tri_level_pulse_decoder_bench;

  localparam int TICK_DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0;
  logic ctl_below = 1'b0, ctl_above = 1'b0, ctl_prog = 1'b0, count_en = 1'b0;
  logic inc_req, dec_req, prog_req;

  int n_chk = 0, n_fail = 0;
  int n_inc = 0, n_dec = 0, n_prog = 0;
  int div = 0;
  bit primed = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  tri_level_pulse_decoder u_tri_level_pulse_decoder (
    .clk(clk), .rst(rst), .tick_us(tick_us),
    .ctl_below(ctl_below), .ctl_above(ctl_above), .ctl_prog(ctl_prog),
    .count_en(count_en),
    .inc_req(inc_req), .dec_req(dec_req), .prog_req(prog_req)
  );

  always @(negedge clk) begin
    div     <= (div == TICK_DIV - 1) ? 0 : div + 1;
    tick_us <= (div == TICK_DIV - 1);
    if (!rst) begin
      n_inc  <= n_inc + int'(inc_req);
      n_dec  <= n_dec + int'(dec_req);
      n_prog <= n_prog + int'(prog_req);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic excursion(input logic lo, input logic hi, input logic pg,
                           input int width, input int gap);
    ctl_below = lo; ctl_above = hi; ctl_prog = pg;
    wait_ticks(width);
    ctl_below = 1'b0; ctl_above = 1'b0; ctl_prog = 1'b0;
    wait_ticks(gap);
  endtask

  // one excursion followed by a settling gap, then strobe-count comparison
  task automatic run_chk(input string req, input logic lo, input logic hi, input logic pg,
                         input int width, input int ei, input int ed, input int ep);
    int i0, d0, p0;
    i0 = n_inc; d0 = n_dec; p0 = n_prog;
    excursion(lo, hi, pg, width, 20);
    check({req, " inc"},  n_inc - i0,  ei);
    check({req, " dec"},  n_dec - d0,  ed);
    check({req, " prog"}, n_prog - p0, ep);
  endtask

  // bench model of the discard rule for a counting pulse that qualifies
  function automatic int model_count(input bit qualifies);
    if (!qualifies) return 0;
    if (!primed) begin
      primed = 1'b1;
      return 0;
    end
    return 1;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int i0, d0;
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    check("R11 inc reset", int'(inc_req), 0);
    check("R11 dec reset", int'(dec_req), 0);
    check("R11 prog reset", int'(prog_req), 0);
    rst = 1'b0;
    wait_ticks(20);

    // R7: enable low, long pulses do nothing
    run_chk("R7 low excursion en=0", 1'b1, 1'b0, 1'b0, 250, 0, 0, 0);

    // R8: pulse right after enable rises is dropped and keeps the discard pending
    count_en = 1'b1;
    run_chk("R8 before startup", 1'b1, 1'b0, 1'b0, 250, 0, 0, 0);
    wait_ticks(900);
    // R5: first honoured pulse discarded
    run_chk("R5 first pulse discarded", 1'b1, 1'b0, 1'b0, 250, 0, 0, 0);
    primed = 1'b1;
    run_chk("R1 increment", 1'b1, 1'b0, 1'b0, 250, 1, 0, 0);
    run_chk("R1 decrement", 1'b0, 1'b1, 1'b0, 260, 0, 1, 0);
    run_chk("R3 long hold once", 1'b1, 1'b0, 1'b0, 600, 1, 0, 0);
    run_chk("R2 glitch", 1'b1, 1'b0, 1'b0, 10, 0, 0, 0);
    run_chk("R2 mid width", 1'b0, 1'b1, 1'b0, 150, 0, 0, 0);
    run_chk("R2 just short", 1'b1, 1'b0, 1'b0, 197, 0, 0, 0);
    run_chk("R10 invalid", 1'b1, 1'b1, 1'b0, 250, 0, 0, 0);

    // R4: short middle gap makes the next excursion ignored
    i0 = n_inc;
    excursion(1'b1, 1'b0, 1'b0, 250, 3);
    excursion(1'b1, 1'b0, 1'b0, 250, 20);
    check("R4 short gap", n_inc - i0, 1);
    // direct low-to-high switch with no middle level
    d0 = n_dec;
    ctl_below = 1'b1; wait_ticks(50);
    ctl_below = 1'b0; ctl_above = 1'b1; wait_ticks(250);
    ctl_above = 1'b0; wait_ticks(20);
    check("R4 no middle between", n_dec - d0, 0);

    // R9: program with enable high; the excursion itself never decrements
    run_chk("R9 program en=1", 1'b0, 1'b1, 1'b1, 250, 0, 0, 1);
    primed = 1'b0;
    run_chk("R6 discard after program", 1'b0, 1'b1, 1'b0, 250, 0, 0, 0);
    primed = 1'b1;
    run_chk("R6 count after discard", 1'b0, 1'b1, 1'b0, 250, 0, 1, 0);

    // R9: program with enable low
    count_en = 1'b0;
    wait_ticks(5);
    run_chk("R9 program en=0", 1'b0, 1'b1, 1'b1, 250, 0, 0, 1);
    primed = 1'b0;
    run_chk("R9 short program", 1'b0, 1'b1, 1'b1, 120, 0, 0, 0);
    count_en = 1'b1;
    wait_ticks(1100);

    // random phase against the model
    for (int k = 0; k < 30; k++) begin
      bit dn, lng, bad;
      int w, e;
      dn  = ($urandom % 2) == 1;
      lng = ($urandom % 3) != 0;
      bad = ($urandom % 8) == 0;
      w   = lng ? 230 + ($urandom % 70) : 5 + ($urandom % 140);
      e   = model_count(lng && !bad);
      run_chk(bad ? "R10 random" : (lng ? "R1 random" : "R2 random"),
              bad ? 1'b1 : !dn, bad ? 1'b1 : dn, 1'b0, w,
              dn ? 0 : e, dn ? e : 0, 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule